// File: doc/BRIEF.md
# SPI Device Status Poller with Maskable Interrupts

This block polls a device on an SPI bus until the device reports the state software is waiting for. Software loads a command byte, the index of a response bit, the value that bit should have, and a small timeout value, then sets a start bit. From then on the block works alone. On each try it selects the device and sends the command byte. It then clocks in one response byte, deselects the device and tests the chosen bit. It stops on the first match, or when its try budget is used up. The budget is (31 shifted left by the 3-bit clock-select input) plus the timeout value.

The block does not shift bits itself. It hands each byte to an external shift engine through a request/acknowledge pair: the request is a level held until a one-cycle acknowledge returns the received byte. Three events are latched in a status register: try finished, poll success and poll timeout. Software clears a latched bit by writing 1 to it. A mask register keeps chosen events off the interrupt line, which pulses for one cycle when an unmasked status bit becomes set.

Top module: `spi_autopoll`

## Requirements
- R1: After reset the poll register, mask register and status register all read 0, and `spi_cs`, `byte_req` and `irq` are low.
- R2: Register address 0 is the poll register. It holds the command in bits 7:0, the timeout in bits 19:16, the bit index in bits 26:24 and the match value in bit 30. Bit 31 reads 1 while polling. A write while idle stores these fields, and it starts polling when bit 31 is 1. Bits that hold no field read 0.
- R3: Each try raises `spi_cs` and then issues two byte requests: the first carries the command byte and the second carries 0x00. `spi_cs` is low for at least one cycle between tries, so `spi_cs` rises once per try.
- R4: If no try matches, exactly (31 << clk_sel) + timeout tries are made. Status bit 2 (timeout) is then set and busy clears. `clk_sel` is sampled at start.
- R5: A try matches when response bit [index] equals the match value. On a match, status bit 1 (success) is set, busy clears and no further try is made.
- R6: Every completed try sets status bit 0 (try finished).
- R7: Status is register address 2. Writing 1 to a bit clears it, and a bit written 0 keeps its value.
- R8: When an event and a write-1-clear of the same status bit fall in the same cycle, the bit ends up set.
- R9: The mask is register address 1, bits 2:0, with one bit per status bit. A mask bit of 1 keeps that event off `irq`, but the status bit is still set.
- R10: `irq` is high for exactly one cycle. That is the cycle in which an unmasked status bit first reads 1 after having been 0. Several bits rising together give one pulse.
- R11: A write to address 0 while polling is busy is ignored, and the stored fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Clock-select code used to scale the try budget |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 poll, 1 mask, 2 status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| spi_cs | output | 1 | Device select, high while a try is in progress |
| byte_req | output | 1 | Byte transfer request to the shift engine, held until acknowledged |
| byte_tx | output | 8 | Byte to send for the current request |
| byte_ack | input | 1 | One-cycle acknowledge from the shift engine |
| byte_rx | input | 8 | Byte received, valid with `byte_ack` |
| irq | output | 1 | Interrupt pulse |

## Verification
The poll loop is run with randomly chosen command, bit index, match value, clock select, timeout, mask and engine latency. The try on which the device answers is drawn from before the budget, past it, or never, so the runs separate a success on the drawn try from a timeout after the exact budget. Directed runs pin down the edges: a match on the very last try versus one try too late, the smallest and largest budget, and a match on the first try where two status bits rise together. Further directed cases clear the status in the same cycle as an event, write the poll register mid-run, and use partial write-1-clear patterns. These show that the set takes priority, that busy writes have no effect and that clears act per bit. The interrupt pulse count is predicted from the prior status and the mask, which tells masking apart from status latching.

// File: rtl/spi_poll_pkg.sv
package spi_poll_pkg;

  localparam int SP_DW    = 8;
  localparam int SP_CLKW  = 3;
  localparam int SP_TOW   = 4;
  localparam int SP_IDXW  = $clog2(SP_DW);
  localparam int SP_CNTW  = 5 + (1 << SP_CLKW);
  localparam int SP_NEVT  = 3;
  localparam int SP_REGW  = 32;
  localparam int SP_ADRW  = 2;

  // software-visible field positions
  localparam int F_CMD_LSB = 0;
  localparam int F_TMO_LSB = 16;
  localparam int F_IDX_LSB = 24;
  localparam int F_POL_BIT = 30;
  localparam int F_GO_BIT  = 31;

  // status bit positions
  localparam int EV_DONE = 0;
  localparam int EV_OK   = 1;
  localparam int EV_TMO  = 2;

  localparam logic [SP_ADRW-1:0] A_POLL = 2'd0;
  localparam logic [SP_ADRW-1:0] A_MASK = 2'd1;
  localparam logic [SP_ADRW-1:0] A_STAT = 2'd2;

  typedef enum logic [1:0] {PS_IDLE, PS_CMD, PS_RSP, PS_EVAL} poll_state_e;

  typedef struct packed {
    logic               pol;
    logic [SP_IDXW-1:0] idx;
    logic [SP_TOW-1:0]  tmo;
    logic [SP_DW-1:0]   cmd;
  } poll_cfg_t;

  function automatic logic [SP_CNTW-1:0] tries_budget(input logic [SP_CLKW-1:0] ck,
                                                      input logic [SP_TOW-1:0] tmo);
    return (SP_CNTW'(31) << ck) + SP_CNTW'(tmo);
  endfunction

  function automatic logic bit_hit(input logic [SP_DW-1:0] rx,
                                   input logic [SP_IDXW-1:0] idx,
                                   input logic pol);
    return rx[idx] == pol;
  endfunction

  function automatic poll_cfg_t unpack_cfg(input logic [SP_REGW-1:0] w);
    poll_cfg_t c;
    c.cmd = w[F_CMD_LSB +: SP_DW];
    c.tmo = w[F_TMO_LSB +: SP_TOW];
    c.idx = w[F_IDX_LSB +: SP_IDXW];
    c.pol = w[F_POL_BIT];
    return c;
  endfunction

  function automatic logic [SP_REGW-1:0] pack_cfg(input poll_cfg_t c, input logic busy);
    logic [SP_REGW-1:0] w;
    w = '0;
    w[F_CMD_LSB +: SP_DW]   = c.cmd;
    w[F_TMO_LSB +: SP_TOW]  = c.tmo;
    w[F_IDX_LSB +: SP_IDXW] = c.idx;
    w[F_POL_BIT]            = c.pol;
    w[F_GO_BIT]             = busy;
    return w;
  endfunction

endpackage

// File: rtl/poll_seq.sv
module poll_seq
  import spi_poll_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               go,
  input  poll_cfg_t          cfg_in,
  input  logic [SP_CLKW-1:0] clk_sel,
  input  logic               byte_ack,
  input  logic [SP_DW-1:0]   byte_rx,
  output poll_cfg_t          cfg,
  output logic               busy,
  output logic               spi_cs,
  output logic               byte_req,
  output logic [SP_DW-1:0]   byte_tx,
  output logic               ev_done,
  output logic               ev_ok,
  output logic               ev_tmo
);

  poll_state_e        state_q;
  poll_cfg_t          cfg_q;
  logic [SP_CNTW-1:0] left_q;
  logic [SP_DW-1:0]   rx_q;
  logic               hit;
  logic               last_try;

  // checker-only bookkeeping: budget and tries taken since start
  logic [SP_CNTW-1:0] budget_q;
  logic [SP_CNTW-1:0] taken_q;

  assign hit      = bit_hit(rx_q, cfg_q.idx, cfg_q.pol);
  assign last_try = (left_q == SP_CNTW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      cfg_q   <= '0;
      left_q  <= '0;
      rx_q    <= '0;
    end else begin
      unique case (state_q)
        PS_IDLE: begin
          if (load) cfg_q <= cfg_in;
          if (go) begin
            left_q  <= tries_budget(clk_sel, cfg_in.tmo);
            state_q <= PS_CMD;
          end
        end
        PS_CMD: if (byte_ack) state_q <= PS_RSP;
        PS_RSP: if (byte_ack) begin
          rx_q    <= byte_rx;
          state_q <= PS_EVAL;
        end
        PS_EVAL: begin
          if (hit || last_try) state_q <= PS_IDLE;
          else begin
            left_q  <= left_q - SP_CNTW'(1);
            state_q <= PS_CMD;
          end
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      budget_q <= '0;
      taken_q  <= '0;
    end else if (go && state_q == PS_IDLE) begin
      budget_q <= tries_budget(clk_sel, cfg_in.tmo);
      taken_q  <= '0;
    end else if (ev_done) begin
      taken_q  <= taken_q + SP_CNTW'(1);
    end
  end

  assign cfg      = cfg_q;
  assign busy     = (state_q != PS_IDLE);
  assign spi_cs   = (state_q == PS_CMD) || (state_q == PS_RSP);
  assign byte_req = spi_cs;
  assign byte_tx  = (state_q == PS_CMD) ? cfg_q.cmd : '0;
  assign ev_done  = (state_q == PS_EVAL);
  assign ev_ok    = ev_done && hit;
  assign ev_tmo   = ev_done && !hit && last_try;

  // R3: select drops only right after the response byte was acknowledged
  assert_cs_after_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs) |-> $past(byte_ack));

  // R3: a byte request is never issued with the device deselected
  assert_req_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> spi_cs);

  // R4: timeout only after exactly the budgeted number of tries
  assert_budget_used_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo |-> (taken_q + SP_CNTW'(1) == budget_q));

  // R5: success or timeout ends polling on the next cycle
  assert_stop_on_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ok || ev_tmo) |=> !busy);

  // R5: success and timeout never both fire
  assert_one_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_ok && ev_tmo));

endmodule

// File: rtl/poll_irq.sv
module poll_irq
  import spi_poll_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SP_NEVT-1:0] ev,
  input  logic               mask_wr,
  input  logic               clr_wr,
  input  logic [SP_NEVT-1:0] wbits,
  output logic [SP_NEVT-1:0] status,
  output logic [SP_NEVT-1:0] mask,
  output logic               irq
);

  logic [SP_NEVT-1:0] stat_q, mask_q, clr_bits, stat_nx, rise;
  logic               irq_q;

  assign clr_bits = clr_wr ? wbits : '0;
  // an event in the same cycle as its clear keeps the bit set
  assign stat_nx  = (stat_q & ~clr_bits) | ev;
  assign rise     = stat_nx & ~stat_q & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      irq_q  <= |rise;
      if (mask_wr) mask_q <= wbits;
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq    = irq_q;

  // R8/R6: every event is visible in status on the following cycle
  assert_event_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((status & $past(ev)) == $past(ev)));

  // R10: the interrupt is a single-cycle pulse
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9: a pulse needs a newly set bit that was unmasked
  assert_irq_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & ~$past(status) & ~$past(mask)) != '0));

  // R7: without a clear or event a status bit holds
  assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && ev == '0) |=> $stable(status));

endmodule

// File: rtl/spi_autopoll.sv
module spi_autopoll
  import spi_poll_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SP_CLKW-1:0] clk_sel,
  input  logic               wr_en,
  input  logic [SP_ADRW-1:0] wr_addr,
  input  logic [SP_REGW-1:0] wr_data,
  input  logic [SP_ADRW-1:0] rd_addr,
  output logic [SP_REGW-1:0] rd_data,
  output logic               spi_cs,
  output logic               byte_req,
  output logic [SP_DW-1:0]   byte_tx,
  input  logic               byte_ack,
  input  logic [SP_DW-1:0]   byte_rx,
  output logic               irq
);

  poll_cfg_t          cfg;
  logic               busy;
  logic               wr_poll, load, go;
  logic               ev_done, ev_ok, ev_tmo;
  logic [SP_NEVT-1:0] ev, status, mask;
  logic               unused_wbits;

  assign wr_poll = wr_en && (wr_addr == A_POLL);
  assign load    = wr_poll && !busy;
  assign go      = load && wr_data[F_GO_BIT];

  assign unused_wbits = ^{wr_data[29:27], wr_data[23:20], wr_data[15:8]};

  poll_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .go       (go),
    .cfg_in   (unpack_cfg(wr_data)),
    .clk_sel  (clk_sel),
    .byte_ack (byte_ack),
    .byte_rx  (byte_rx),
    .cfg      (cfg),
    .busy     (busy),
    .spi_cs   (spi_cs),
    .byte_req (byte_req),
    .byte_tx  (byte_tx),
    .ev_done  (ev_done),
    .ev_ok    (ev_ok),
    .ev_tmo   (ev_tmo)
  );

  always_comb begin
    ev          = '0;
    ev[EV_DONE] = ev_done;
    ev[EV_OK]   = ev_ok;
    ev[EV_TMO]  = ev_tmo;
  end

  poll_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .mask_wr (wr_en && (wr_addr == A_MASK)),
    .clr_wr  (wr_en && (wr_addr == A_STAT)),
    .wbits   (wr_data[SP_NEVT-1:0]),
    .status  (status),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    unique case (rd_addr)
      A_POLL:  rd_data = pack_cfg(cfg, busy);
      A_MASK:  rd_data = SP_REGW'(mask);
      A_STAT:  rd_data = SP_REGW'(status);
      default: rd_data = '0;
    endcase
  end

  // R11: a poll-register write during a run leaves the fields alone
  assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_poll && busy) |=> $stable(cfg));

  // R2: a start request while idle makes the block busy
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

endmodule

// File: tb/tb_spi_autopoll.sv
module tb_spi_autopoll;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  clk_sel = '0;
  logic        m_wr = 1'b0, e_wr = 1'b0;
  logic [1:0]  m_addr = '0;
  logic [31:0] m_data = '0;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        spi_cs, byte_req, irq;
  logic [7:0]  byte_tx;
  logic        byte_ack = 1'b0;
  logic [7:0]  byte_rx = '0;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  assign wr_en   = m_wr | e_wr;
  assign wr_addr = e_wr ? 2'd2 : m_addr;
  assign wr_data = e_wr ? 32'd7 : m_data;

  spi_autopoll dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .spi_cs(spi_cs), .byte_req(byte_req), .byte_tx(byte_tx),
    .byte_ack(byte_ack), .byte_rx(byte_rx), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] poll_word(input logic busy, input logic pol,
      input logic [2:0] idx, input logic [3:0] to, input logic [7:0] cmd);
    return {busy, pol, 3'b000, idx, 4'b0000, to, 8'h00, cmd};
  endfunction

  function automatic int budget(input logic [2:0] ck, input logic [3:0] to);
    return 31 * (2 ** ck) + int'(to);
  endfunction

  // ---------------- shift-engine model ----------------
  logic [7:0] run_cmd = '0;
  logic [2:0] run_idx = '0;
  logic       run_pol = 1'b0;
  int run_match = -1, run_base = 0, e_lat = 0, clr_abs = -1;
  int e_wait = 0, byte_n = 0, try_n = 0, tx_err = 0, cs_rise = 0, irq_hi = 0;
  logic e_pend = 1'b0, cs_last = 1'b0;

  always @(negedge clk) begin
    logic [7:0] rb;
    if (!rst_n) begin
      byte_ack = 1'b0; e_wait = 0; e_wr = 1'b0; e_pend = 1'b0; cs_last = 1'b0;
    end else begin
      if (spi_cs && !cs_last) cs_rise++;
      cs_last = spi_cs;
      if (irq) irq_hi++;
      e_wr = 1'b0;
      if (byte_ack) begin
        byte_ack = 1'b0;
        if (e_pend) begin e_wr = 1'b1; e_pend = 1'b0; end
      end else if (byte_req) begin
        if (e_wait >= e_lat) begin
          e_wait = 0;
          if (!spi_cs) tx_err++;
          if (byte_n % 2 == 0) begin
            if (byte_tx !== run_cmd) tx_err++;
            byte_rx = 8'($urandom);
          end else begin
            if (byte_tx !== 8'h00) tx_err++;
            rb = 8'($urandom);
            rb[run_idx] = ((try_n - run_base) == run_match) ? run_pol : ~run_pol;
            byte_rx = rb;
            if (try_n == clr_abs) e_pend = 1'b1;
            try_n++;
          end
          byte_n++;
          byte_ack = 1'b1;
        end else e_wait++;
      end
    end
  end

  // ---------------- register access ----------------
  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); m_wr = 1'b1; m_addr = a; m_data = d;
    @(negedge clk); m_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  // ---------------- one polling run ----------------
  task automatic run(input string tag, input logic [7:0] cmd, input logic [3:0] to,
      input logic [2:0] idx, input logic pol, input logic [2:0] ck, input int m_at,
      input logic [2:0] msk, input int lat, input bit mid, input bit keep,
      input int clr_at, input logic [2:0] exp_override);
    logic [31:0] d, w;
    logic [2:0]  prior, expst;
    int total, exp_tries, fbit, r0, rf, exp_irq, t0, c0, i0, x0, guard;
    bit matched;
    total     = budget(ck, to);
    matched   = (m_at >= 0) && (m_at < total);
    exp_tries = matched ? m_at + 1 : total;
    fbit      = matched ? 1 : 2;
    clk_sel   = ck;
    reg_write(2'd1, {29'd0, msk});
    if (!keep) begin
      reg_write(2'd2, 32'd7);
      reg_read(2'd2, d);
      chk({tag, " R7 clear-all"}, d, 32'd0);
    end
    reg_read(2'd2, d); prior = d[2:0];
    run_cmd = cmd; run_idx = idx; run_pol = pol; run_match = m_at; e_lat = lat;
    run_base = try_n; clr_abs = (clr_at < 0) ? -1 : try_n + clr_at;
    t0 = try_n; c0 = cs_rise; i0 = irq_hi; x0 = tx_err;
    w = poll_word(1'b1, pol, idx, to, cmd);
    reg_write(2'd0, w);
    reg_read(2'd0, d);
    chk({tag, " R2 busy readback"}, d, w);
    if (mid) reg_write(2'd0, ~w | 32'h8000_0000);
    guard = 0;
    do begin
      @(negedge clk); reg_read(2'd0, d); guard++;
    end while (d[31] && guard < 60000);
    chk({tag, " R11 fields after run"}, d, poll_word(1'b0, pol, idx, to, cmd));
    chk({tag, " R4/R5 tries"}, try_n - t0, exp_tries);
    chk({tag, " R3 cs per try"}, cs_rise - c0, exp_tries);
    chk({tag, " R3 tx bytes"}, tx_err - x0, 0);
    expst = prior | 3'b001 | (3'b001 << fbit);
    if (exp_override != 3'b000) expst = exp_override;
    reg_read(2'd2, d);
    chk({tag, matched ? " R5/R6/R9 status" : " R4/R6/R9 status"}, d, {29'd0, expst});
    r0 = (!prior[0] && !msk[0]) ? 1 : 0;
    rf = (!prior[fbit] && !msk[fbit]) ? 1 : 0;
    exp_irq = (exp_tries == 1) ? ((r0 + rf > 0) ? 1 : 0) : r0 + rf;
    chk({tag, " R9/R10 irq pulses"}, irq_hi - i0, exp_irq);
    clr_abs = -1;
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int sd;
    sd = int'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_read(2'd0, d); chk("R1 poll reg", d, 0);
    reg_read(2'd1, d); chk("R1 mask reg", d, 0);
    reg_read(2'd2, d); chk("R1 status reg", d, 0);
    chk("R1 outputs", {29'd0, spi_cs, byte_req, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 idle write without start stores fields, stays idle
    reg_write(2'd0, poll_word(1'b0, 1'b1, 3'd5, 4'd9, 8'hA7) | 32'h0870_FF00);
    reg_read(2'd0, d);
    chk("R2 idle store", d, poll_word(1'b0, 1'b1, 3'd5, 4'd9, 8'hA7));
    chk("R2 no start", {31'd0, spi_cs}, 0);

    // directed corners
    run("min budget timeout", 8'h05, 4'd0, 3'd0, 1'b1, 3'd0, -1, 3'b000, 0, 1'b0, 1'b0, -1, 3'b000);
    run("match last try",     8'h9F, 4'd3, 3'd7, 1'b0, 3'd1, 64, 3'b000, 1, 1'b1, 1'b0, -1, 3'b000);
    run("match one too late", 8'h9F, 4'd3, 3'd7, 1'b0, 3'd1, 65, 3'b010, 1, 1'b0, 1'b0, -1, 3'b000);
    run("first try match",    8'h3C, 4'd1, 3'd2, 1'b1, 3'd0, 0, 3'b000, 2, 1'b0, 1'b0, -1, 3'b000);
    run("all masked",         8'h11, 4'd2, 3'd4, 1'b0, 3'd0, 10, 3'b111, 0, 1'b1, 1'b0, -1, 3'b000);

    // R7 partial clear: status is 011 after the success run above
    reg_write(2'd2, 32'd1);
    reg_read(2'd2, d); chk("R7 partial clear", d, 32'd2);
    reg_write(2'd2, 32'd0);
    reg_read(2'd2, d); chk("R7 zero write keeps", d, 32'd2);

    // R8 set beats clear: prior status 101, clear-all lands with first try events
    run("prep timeout", 8'h42, 4'd0, 3'd3, 1'b1, 3'd0, -1, 3'b000, 0, 1'b0, 1'b0, -1, 3'b000);
    run("R8 set wins", 8'h43, 4'd0, 3'd3, 1'b1, 3'd0, 0, 3'b000, 1, 1'b0, 1'b1, 0, 3'b011);

    // largest budget
    run("max budget timeout", 8'hE1, 4'd15, 3'd6, 1'b0, 3'd7, -1, 3'b001, 0, 1'b0, 1'b0, -1, 3'b000);

    // constrained random runs
    for (int i = 0; i < 14; i++) begin
      logic [2:0] ck;
      logic [3:0] to;
      int tot, m;
      ck  = 3'($urandom_range(0, 2));
      to  = 4'($urandom);
      tot = budget(ck, to);
      case ($urandom_range(0, 3))
        0: m = -1;
        1: m = tot + int'($urandom_range(0, 4));
        default: m = int'($urandom_range(0, tot - 1));
      endcase
      run("random", 8'($urandom), to, 3'($urandom), 1'($urandom), ck, m,
          3'($urandom), int'($urandom_range(0, 3)), 1'($urandom), 1'b0, -1, 3'b000);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule